// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers sixteen interrupt request lines into a single interrupt signal for a processor. It is built from two identical eight-line priority units. The secondary unit serves lines 8 to 15. Its combined request drives input 2 of the primary unit, which serves lines 0 to 7 and drives the processor's interrupt output. Each unit latches rising edges on its lines, masks them with a byte written by software, and tracks which lines are in service. The interrupt output rises only when a pending request outranks everything currently being serviced.

The processor answers a raised interrupt with a one-cycle acknowledge pulse. In that same cycle the controller places an 8-bit vector on its output, and the vector stays there until the next accepted acknowledge. Software ends a handler by writing an end-of-interrupt command to the unit (or units) involved. A byte-wide write port carries the two mask bytes and the two command bytes. Line 2 cannot be used directly, so a request on it is folded into line 9.

Top module: `pic_cascade`

## Requirements
- R1: After reset `int_o` is 0, `vec_o` is 8'h00, no request or in-service bit is set, and every mask bit is set, so no line can raise `int_o` until software unmasks it.
- R2: A rising edge on a request line is latched as pending and stays pending, even while masked, until that line is acknowledged. A level held high does not latch a second time.
- R3: A write with `wr_addr`=0 loads the primary mask, where bit n controls line n. A write with `wr_addr`=1 loads the secondary mask, where bit n controls line 8+n. A 1 in a mask bit blocks that line.
- R4: Among unmasked pending lines, service order from highest to lowest is 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.
- R5: The vector returned for primary line n (n = 0..7, n != 2) is 8'h08+n. The vector for line 8+n is 8'h70+n.
- R6: A request on line 2 is treated exactly as a request on line 9. It uses line 9's priority and vector 8'h71.
- R7: `int_o` is 1 only while an unmasked pending line ranks above every in-service line (fully nested). A secondary line may still preempt a lower secondary line that is in service.
- R8: An acknowledge pulse seen while `int_o` is 1 moves the winning line from pending to in service. It drives that line's vector on `vec_o` in the same cycle and holds it afterwards. An acknowledge seen while `int_o` is 0 changes nothing.
- R9: A write with `wr_data[5]`=1 to `wr_addr`=2 (primary) or `wr_addr`=3 (secondary) clears that unit's highest-priority in-service bit. A command write with bit 5 clear has no effect. A secondary line needs both commands before the primary input 2 is free.
- R10: A line that is still in service is never issued again. A new edge on that line waits until the line's end-of-interrupt has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 16 | Interrupt request lines 0 to 15, rising-edge sensitive |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 primary mask, 1 secondary mask, 2 primary command, 3 secondary command |
| wr_data | input | 8 | Write data byte |
| ack_i | input | 1 | Interrupt acknowledge pulse from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector byte, valid in the acknowledge cycle and held afterwards |

## Verification
The bench builds the block with its default vector bases, 8'h08 for the primary unit and 8'h70 for the secondary. Because of these bases, every expected vector can be written as a plain constant taken from the requirements. With the cascade fixed on primary input 2, the bench can reach the interleaved priority order. It also reaches the double end-of-interrupt needed for secondary lines, the folding of line 2 into line 9, and nested preemption both between units and inside the secondary unit.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int UNIT_LINES = 8;
  localparam int IDX_W      = $clog2(UNIT_LINES);

  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic hit;
    idx_t idx;
  } pick_t;

  // lowest-numbered set bit wins
  function automatic pick_t first_set(input logic [UNIT_LINES-1:0] v);
    pick_t p;
    p = '0;
    for (int i = UNIT_LINES - 1; i >= 0; i--) begin
      if (v[i]) begin
        p.hit = 1'b1;
        p.idx = idx_t'(i);
      end
    end
    return p;
  endfunction

  // fully nested grant: the request must outrank the highest in-service line.
  // The cascade input may re-enter because the downstream unit nests itself.
  function automatic logic outranks(input pick_t req, input pick_t svc, input int casc);
    logic same_casc;
    same_casc = (casc >= 0) && (int'(req.idx) == casc) && (int'(svc.idx) == casc);
    return req.hit && (!svc.hit || (req.idx < svc.idx) || same_casc);
  endfunction
endpackage

// File: rtl/pic_unit.sv
module pic_unit
  import pic_pkg::*;
#(
  parameter int CASC = -1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [UNIT_LINES-1:0] lines_i,
  input  logic                  casc_i,
  input  logic                  mask_we,
  input  logic [UNIT_LINES-1:0] mask_d,
  input  logic                  eoi_i,
  input  logic                  ack_i,
  output logic                  int_o,
  output idx_t                  win_o,
  output logic [UNIT_LINES-1:0] isr_o
);
  logic [UNIT_LINES-1:0] prev_q, irr_q, imr_q, isr_q;
  logic [UNIT_LINES-1:0] rise, req_eff, pend, irr_d, isr_d;
  pick_t                 req_pick, svc_pick;
  logic                  take;

  assign rise = lines_i & ~prev_q;

  always_comb begin
    req_eff = irr_q;
    for (int i = 0; i < UNIT_LINES; i++) begin
      if (i == CASC) req_eff[i] = casc_i;
    end
  end

  assign pend     = req_eff & ~imr_q;
  assign req_pick = first_set(pend);
  assign svc_pick = first_set(isr_q);
  assign int_o    = outranks(req_pick, svc_pick, CASC);
  assign win_o    = req_pick.idx;
  assign take     = ack_i && int_o;
  assign isr_o    = isr_q;

  always_comb begin
    irr_d = irr_q | rise;
    for (int i = 0; i < UNIT_LINES; i++) begin
      if (i == CASC) irr_d[i] = 1'b0;
    end
    if (take) irr_d[req_pick.idx] = 1'b0;
    isr_d = isr_q;
    if (eoi_i && svc_pick.hit) isr_d[svc_pick.idx] = 1'b0;
    if (take) isr_d[req_pick.idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
      imr_q  <= '1;
    end else begin
      prev_q <= lines_i;
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      if (mask_we) imr_q <= mask_d;
    end
  end
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
  import pic_pkg::*;
#(
  parameter logic [7:0] PRI_BASE  = 8'h08,
  parameter logic [7:0] SEC_BASE  = 8'h70,
  parameter int         CASC_LINE = 2,
  parameter int         FOLD_TO   = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_i,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        ack_i,
  output logic        int_o,
  output logic [7:0]  vec_o
);
  localparam logic [1:0] A_PMASK = 2'd0;
  localparam logic [1:0] A_SMASK = 2'd1;
  localparam logic [1:0] A_PCMD  = 2'd2;
  localparam logic [1:0] A_SCMD  = 2'd3;
  localparam int         EOI_BIT = 5;

  logic [UNIT_LINES-1:0] p_lines, s_lines, p_isr, s_isr;
  logic                  s_int, p_int, p_take, s_take;
  idx_t                  p_win, s_win;
  logic [7:0]            vec_now, vec_q;

  always_comb begin
    p_lines = irq_i[UNIT_LINES-1:0];
    p_lines[CASC_LINE] = 1'b0;
    s_lines = irq_i[2*UNIT_LINES-1:UNIT_LINES];
    s_lines[FOLD_TO] = s_lines[FOLD_TO] | irq_i[CASC_LINE];
  end

  assign p_take = ack_i && p_int;
  assign s_take = p_take && (int'(p_win) == CASC_LINE);

  pic_unit #(.CASC(CASC_LINE)) u_pri (
    .clk(clk), .rst_n(rst_n), .lines_i(p_lines), .casc_i(s_int),
    .mask_we(wr_en && wr_addr == A_PMASK), .mask_d(wr_data),
    .eoi_i(wr_en && wr_addr == A_PCMD && wr_data[EOI_BIT]),
    .ack_i(ack_i), .int_o(p_int), .win_o(p_win), .isr_o(p_isr)
  );

  pic_unit #(.CASC(-1)) u_sec (
    .clk(clk), .rst_n(rst_n), .lines_i(s_lines), .casc_i(1'b0),
    .mask_we(wr_en && wr_addr == A_SMASK), .mask_d(wr_data),
    .eoi_i(wr_en && wr_addr == A_SCMD && wr_data[EOI_BIT]),
    .ack_i(s_take), .int_o(s_int), .win_o(s_win), .isr_o(s_isr)
  );

  assign vec_now = s_take ? (SEC_BASE + 8'(s_win)) : (PRI_BASE + 8'(p_win));

  always_ff @(posedge clk) begin
    if (!rst_n)      vec_q <= '0;
    else if (p_take) vec_q <= vec_now;
  end

  assign int_o = p_int;
  assign vec_o = p_take ? vec_now : vec_q;
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk
  import pic_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ack_i,
  input logic                  int_o,
  input logic [7:0]            vec_o,
  input logic                  p_take,
  input logic                  s_take,
  input logic                  s_int,
  input idx_t                  p_win,
  input idx_t                  s_win,
  input logic [UNIT_LINES-1:0] p_isr,
  input logic [UNIT_LINES-1:0] s_isr
);
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    p_take |=> p_isr[$past(p_win)]);  // R8
  AST_SEC_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    s_take |=> s_isr[$past(s_win)]);  // R8
  AST_NO_REISSUE_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    (int_o && p_win != idx_t'(2)) |-> !p_isr[p_win]);  // R10
  AST_NO_REISSUE_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    s_int |-> !s_isr[s_win]);  // R10
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |-> $stable(vec_o));  // R8
  AST_SEC_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    s_take |-> (vec_o[7:3] == 5'b01110));  // R5
  AST_PRI_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (p_take && !s_take) |-> (vec_o[7:3] == 5'b00001));  // R5
endmodule

bind pic_cascade pic_cascade_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .int_o(int_o), .vec_o(vec_o),
  .p_take(p_take), .s_take(s_take), .s_int(s_int), .p_win(p_win),
  .s_win(s_win), .p_isr(p_isr), .s_isr(s_isr)
);

// File: tb/pic_cascade_tb.sv
module pic_cascade_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_i = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        ack_i = 1'b0;
  logic        int_o;
  logic [7:0]  vec_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_cascade u_dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ack_i(ack_i), .int_o(int_o), .vec_o(vec_o)
  );

  // monitor: compares every acknowledge vector against the scoreboard
  always @(negedge clk) begin
    #1;
    if (ack_i) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected acknowledge vec=%h", vec_o);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (vec_o !== e) begin
          errors++;
          $display("FAIL %s vector got %h exp %h", t, vec_o, e);
        end
      end
    end
  end

  task automatic pulse(input logic [15:0] m);
    @(negedge clk) irq_i = m;
    @(negedge clk) irq_i = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic ack(input logic [7:0] e, input string t);
    @(negedge clk) begin exp_q.push_back(e); tag_q.push_back(t); ack_i = 1'b1; end
    @(negedge clk) ack_i = 1'b0;
  endtask

  task automatic chk_int(input logic e, input string t);
    #1;
    checks++;
    if (int_o !== e) begin
      errors++;
      $display("FAIL %s int_o got %b exp %b", t, int_o, e);
    end
  endtask

  task automatic chk_vec(input logic [7:0] e, input string t);
    #1;
    checks++;
    if (vec_o !== e) begin
      errors++;
      $display("FAIL %s vec_o got %h exp %h", t, vec_o, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_int(1'b0, "R1 reset");
    chk_vec(8'h00, "R1 reset");
    pulse(16'h0001);
    chk_int(1'b0, "R1 masked after reset");
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    chk_int(1'b1, "R2 latched while masked");
    ack(8'h08, "R5 line0");
    chk_int(1'b0, "R10 line0 in service");
    pulse(16'h0001);
    chk_int(1'b0, "R10 no reissue");
    wr(2'd2, 8'h00);
    chk_int(1'b0, "R9 command without eoi bit");
    wr(2'd2, 8'h20);
    chk_int(1'b1, "R9 eoi frees line0");
    ack(8'h08, "R10 reissue after eoi");
    wr(2'd2, 8'h20);
    // priority across cascade
    pulse(16'h1022);
    chk_int(1'b1, "R4 three pending");
    ack(8'h09, "R4 line1 first");
    chk_int(1'b0, "R7 line12 below line1");
    wr(2'd2, 8'h20);
    chk_int(1'b1, "R4 line12 next");
    ack(8'h74, "R4 line12 vector");
    chk_int(1'b0, "R7 line5 below cascade");
    wr(2'd3, 8'h20);
    chk_int(1'b0, "R9 primary still busy");
    wr(2'd2, 8'h20);
    chk_int(1'b1, "R9 both eoi written");
    ack(8'h0D, "R4 line5 last");
    wr(2'd2, 8'h20);
    chk_int(1'b0, "R4 nothing left");
    // nested preemption on primary
    pulse(16'h0080);
    ack(8'h0F, "R5 line7");
    pulse(16'h0008);
    chk_int(1'b1, "R7 line3 preempts line7");
    ack(8'h0B, "R7 line3");
    pulse(16'h0040);
    chk_int(1'b0, "R7 line6 below line3");
    wr(2'd2, 8'h20);
    chk_int(1'b1, "R7 line6 above line7");
    ack(8'h0E, "R7 line6");
    wr(2'd2, 8'h20);
    wr(2'd2, 8'h20);
    chk_int(1'b0, "R9 primary clear");
    // legacy line 2
    pulse(16'h0004);
    chk_int(1'b1, "R6 line2 request");
    ack(8'h71, "R6 line2 folded");
    wr(2'd3, 8'h20);
    wr(2'd2, 8'h20);
    // secondary nesting
    pulse(16'h0400);
    ack(8'h72, "R5 line10");
    pulse(16'h0100);
    chk_int(1'b1, "R7 line8 preempts line10");
    ack(8'h70, "R7 line8");
    chk_int(1'b0, "R7 both serviced");
    wr(2'd3, 8'h20);
    wr(2'd3, 8'h20);
    wr(2'd2, 8'h20);
    chk_int(1'b0, "R9 all clear");
    // secondary mask
    wr(2'd1, 8'h08);
    pulse(16'h0800);
    chk_int(1'b0, "R3 line11 masked");
    pulse(16'h4000);
    chk_int(1'b1, "R3 line14 unmasked");
    ack(8'h76, "R3 line14");
    wr(2'd3, 8'h20);
    wr(2'd2, 8'h20);
    wr(2'd1, 8'h00);
    chk_int(1'b1, "R3 line11 after unmask");
    ack(8'h73, "R3 line11");
    wr(2'd3, 8'h20);
    wr(2'd2, 8'h20);
    // primary mask bit
    wr(2'd0, 8'h10);
    pulse(16'h0010);
    chk_int(1'b0, "R3 line4 masked");
    wr(2'd0, 8'h00);
    ack(8'h0C, "R3 line4 after unmask");
    wr(2'd2, 8'h20);
    // ack ignored while idle, vector holds
    chk_int(1'b0, "R8 idle");
    ack(8'h0C, "R8 ignored ack");
    repeat (3) @(negedge clk);
    chk_vec(8'h0C, "R8 vector held");
    chk_int(1'b0, "R8 ignored ack no state");
    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R8 missing acknowledges got %0d exp 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule